// File: doc/BRIEF.md
# Conditional set instruction unit

This unit decodes and runs one opcode of a small 16-bit processor: "set on condition". It receives the instruction as a stream of 16-bit words. The first word carries the opcode in bits 5:0, the destination operand mode in bits 10:6 and the source operand mode in bits 15:11. The source must be a 16-bit immediate. That immediate is the selector, and it picks one of fourteen tests on the carry (C), zero (Z), sign (S) and overflow (O) flags. The destination receives 1 when the test holds and 0 when it does not. The destination is either a register or a memory word.

Extension words follow the first word. The selector word always comes first. The destination's address or displacement word, when that mode needs one, comes after it. Three streams use valid/ready:

- **Instruction words.** A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a write request is pending, so the instruction source is held back during that time.
- **Register writes and memory writes.** Each request holds its valid and its payload steady until the matching ready is high on a clock edge.

Exactly one write is made per legal instruction. The unit signals the end of the instruction with `done_o`, and an illegal instruction with `illegal_o`. The flags are inputs only and are never changed.

Operand modes, with NREG=8: 0..7 is register n; 8..15 is memory at [register n-8]; 16..23 is memory at [register n-16 + displacement word]; 30 is memory at [address word]; 31 is a 16-bit immediate. Modes 24..29 are undefined.

Top module: `setcc_unit`

## Requirements
- R1: A first word whose bits 5:0 differ from the parameter OPCODE (default 50; 0 and 63 belong to other instructions) gives a one-cycle `illegal_o` in the cycle after it is accepted. That instruction makes no write, and the next word is taken as a new first word.
- R2: A source mode (bits 15:11) other than 31 gives a one-cycle `illegal_o` in the cycle after the first word is accepted, and no write.
- R3: A destination mode (bits 10:6) of 31, or of 24..29, gives a one-cycle `illegal_o` in the cycle after the first word is accepted, and no write.
- R4: A selector above 13 gives `illegal_o` and no write. It is raised after the destination's extension word, if there is one, has been consumed, so the stream stays aligned.
- R5: Unsigned selectors: 0 above (C=0 and Z=0), 1 above-or-equal (C=0), 2 below-or-equal (C=1 or Z=1), 3 below (C=1).
- R6: Equality selectors: 4 equal (Z=1), 5 not-equal (Z=0).
- R7: Signed selectors: 6 greater (S==O and Z=0), 7 greater-or-equal (S==O), 8 less-or-equal (S!=O or Z=1), 9 less (S!=O).
- R8: Selectors 10 overflow (O=1), 11 no-overflow (O=0), 12 sign (S=1), 13 no-sign (S=0).
- R9: For a register destination, one register write request is made with `reg_wr_sel` equal to the mode and data 0x0001 or 0x0000. No memory request is made at the same time.
- R10: For destination mode 30, one memory write request is made with the address equal to the extension word.
- R11: For mode 8+n the memory address is the value read from register n. For mode 16+n it is that value plus the displacement word, modulo 2^16. Register n is read through `rf_rd_sel`.
- R12: A pending write request keeps its valid and its data stable until ready is high, and `in_ready` is low meanwhile.
- R13: `done_o` is high for exactly the one cycle after the write request is accepted. It is never high in the same cycle as `illegal_o`.
- R14: The flags are sampled on the clock edge that accepts the selector word. Later changes to the flags do not alter the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Unit can take an instruction word |
| in_word | input | 16 | Instruction or extension word |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| rf_rd_sel | output | 3 | Register read index for address forming |
| rf_rd_data | input | 16 | Register read value |
| reg_wr_valid | output | 1 | Register write request |
| reg_wr_ready | input | 1 | Register write accepted |
| reg_wr_sel | output | 3 | Register to write |
| reg_wr_data | output | 16 | Value to write (0 or 1) |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 16 | Value to write (0 or 1) |
| done_o | output | 1 | Instruction finished pulse |
| illegal_o | output | 1 | Illegal instruction pulse |

## Verification
The bench runs every selector against all sixteen flag combinations. A wrong entry in the predicate table, or mixing up S!=O with S==O, therefore shows up as a wrong written bit. A bad selector is sent with a destination that carries an address word, followed by a legal instruction. A unit that raised the fault too early would read that address word as a new opcode and fault a second time.

Other corner cases covered:

- A displacement that wraps past 0xFFFF exposes a carry kept or a wrong operand order.
- A stalled write ready exposes a request that drops or changes before acceptance.
- Flags changed after the selector word is taken expose late sampling.

// File: rtl/setcc_pkg.sv
package setcc_pkg;

  localparam int MODE_W = 5;
  localparam int WORD_W = 16;
  localparam int NUM_COND = 14;
  localparam logic [MODE_W-1:0] MODE_IMM = 5'd31;
  localparam logic [MODE_W-1:0] MODE_ABS = 5'd30;

  typedef enum logic [2:0] {
    OPK_IMM,
    OPK_REG,
    OPK_MEM_REG,
    OPK_MEM_DISP,
    OPK_MEM_ABS,
    OPK_BAD
  } opk_e;

  typedef enum logic [1:0] {
    ST_HEAD,
    ST_SEL,
    ST_EXT,
    ST_PUT
  } seq_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
  } flags_t;

endpackage

// File: rtl/setcc_mode_decode.sv
module setcc_mode_decode
  import setcc_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RSEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [MODE_W-1:0] mode,
  output opk_e              kind,
  output logic [RSEL_W-1:0] rsel,
  output logic              needs_ext
);

  localparam logic [MODE_W-1:0] IND_BASE  = MODE_W'(NREG);
  localparam logic [MODE_W-1:0] DISP_BASE = MODE_W'(2 * NREG);
  localparam logic [MODE_W-1:0] TOP_END   = MODE_W'(3 * NREG);

  logic [MODE_W-1:0] off;

  always_comb begin
    kind      = OPK_BAD;
    needs_ext = 1'b0;
    off       = '0;
    if (mode == MODE_IMM) begin
      kind      = OPK_IMM;
      needs_ext = 1'b1;
    end else if (mode == MODE_ABS) begin
      kind      = OPK_MEM_ABS;
      needs_ext = 1'b1;
    end else if (mode < IND_BASE) begin
      kind = OPK_REG;
      off  = mode;
    end else if (mode < DISP_BASE) begin
      kind = OPK_MEM_REG;
      off  = mode - IND_BASE;
    end else if (mode < TOP_END) begin
      kind      = OPK_MEM_DISP;
      needs_ext = 1'b1;
      off       = mode - DISP_BASE;
    end
    rsel = off[RSEL_W-1:0];
  end

endmodule

// File: rtl/setcc_cond_eval.sv
module setcc_cond_eval
  import setcc_pkg::*;
(
  input  flags_t            flags,
  input  logic [WORD_W-1:0] selector,
  output logic              hit,
  output logic              sel_ok
);

  logic [15:0] truth;
  logic        s_eq_o;

  always_comb begin
    s_eq_o    = (flags.s == flags.o);
    truth     = '0;
    truth[0]  = !flags.c && !flags.z;
    truth[1]  = !flags.c;
    truth[2]  = flags.c || flags.z;
    truth[3]  = flags.c;
    truth[4]  = flags.z;
    truth[5]  = !flags.z;
    truth[6]  = s_eq_o && !flags.z;
    truth[7]  = s_eq_o;
    truth[8]  = !s_eq_o || flags.z;
    truth[9]  = !s_eq_o;
    truth[10] = flags.o;
    truth[11] = !flags.o;
    truth[12] = flags.s;
    truth[13] = !flags.s;
    sel_ok    = (selector < WORD_W'(NUM_COND));
    hit       = sel_ok && truth[selector[3:0]];
  end

endmodule

// File: rtl/setcc_addr_gen.sv
module setcc_addr_gen
  import setcc_pkg::*;
(
  input  opk_e              kind,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] ext,
  output logic [WORD_W-1:0] addr
);

  always_comb begin
    unique case (kind)
      OPK_MEM_ABS:  addr = ext;
      OPK_MEM_REG:  addr = base;
      OPK_MEM_DISP: addr = base + ext;
      default:      addr = '0;
    endcase
  end

endmodule

// File: rtl/setcc_unit.sv
module setcc_unit
  import setcc_pkg::*;
#(
  parameter int OPCODE = 50,
  parameter int NREG = 8,
  localparam int RSEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_word,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_o,
  output logic [RSEL_W-1:0] rf_rd_sel,
  input  logic [15:0]       rf_rd_data,
  output logic              reg_wr_valid,
  input  logic              reg_wr_ready,
  output logic [RSEL_W-1:0] reg_wr_sel,
  output logic [15:0]       reg_wr_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [15:0]       mem_wr_addr,
  output logic [15:0]       mem_wr_data,
  output logic              done_o,
  output logic              illegal_o
);

  localparam logic [5:0] OPC = 6'(OPCODE);

  seq_e              state_q;
  opk_e              src_kind, dst_kind, dst_kind_q;
  logic [RSEL_W-1:0] src_rsel, dst_rsel, dst_rsel_q;
  logic              src_ext, dst_ext, dst_ext_q;
  logic              hit, sel_ok, hit_q, bad_sel_q;
  logic [15:0]       ext_q;
  logic              done_q, illegal_q;
  logic              take, head_bad, to_reg, wr_fire;
  flags_t            flags;

  assign flags = '{c: flag_c, z: flag_z, s: flag_s, o: flag_o};

  setcc_mode_decode #(.NREG(NREG)) i_src_dec (
    .mode(in_word[15:11]), .kind(src_kind), .rsel(src_rsel), .needs_ext(src_ext)
  );

  setcc_mode_decode #(.NREG(NREG)) i_dst_dec (
    .mode(in_word[10:6]), .kind(dst_kind), .rsel(dst_rsel), .needs_ext(dst_ext)
  );

  setcc_cond_eval i_cond (
    .flags(flags), .selector(in_word), .hit(hit), .sel_ok(sel_ok)
  );

  setcc_addr_gen i_addr (
    .kind(dst_kind_q), .base(rf_rd_data), .ext(ext_q), .addr(mem_wr_addr)
  );

  assign in_ready = (state_q != ST_PUT);
  assign take     = in_valid && in_ready;
  assign head_bad = (in_word[5:0] != OPC) || (src_kind != OPK_IMM) ||
                    (dst_kind == OPK_IMM) || (dst_kind == OPK_BAD) ||
                    (src_rsel != '0 && src_ext == 1'b0);
  assign to_reg   = (dst_kind_q == OPK_REG);

  assign reg_wr_valid = (state_q == ST_PUT) && to_reg;
  assign mem_wr_valid = (state_q == ST_PUT) && !to_reg;
  assign reg_wr_sel   = dst_rsel_q;
  assign rf_rd_sel    = dst_rsel_q;
  assign reg_wr_data  = {15'd0, hit_q};
  assign mem_wr_data  = {15'd0, hit_q};
  assign wr_fire      = (reg_wr_valid && reg_wr_ready) || (mem_wr_valid && mem_wr_ready);
  assign done_o       = done_q;
  assign illegal_o    = illegal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HEAD;
      dst_kind_q <= OPK_BAD;
      dst_rsel_q <= '0;
      dst_ext_q  <= 1'b0;
      hit_q      <= 1'b0;
      bad_sel_q  <= 1'b0;
      ext_q      <= '0;
      done_q     <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      unique case (state_q)
        ST_HEAD: if (take) begin
          dst_kind_q <= dst_kind;
          dst_rsel_q <= dst_rsel;
          dst_ext_q  <= dst_ext;
          if (head_bad) illegal_q <= 1'b1;
          else          state_q   <= ST_SEL;
        end
        ST_SEL: if (take) begin
          hit_q     <= hit;
          bad_sel_q <= !sel_ok;
          if (dst_ext_q) begin
            state_q <= ST_EXT;
          end else if (!sel_ok) begin
            illegal_q <= 1'b1;
            state_q   <= ST_HEAD;
          end else begin
            state_q <= ST_PUT;
          end
        end
        ST_EXT: if (take) begin
          ext_q <= in_word;
          if (bad_sel_q) begin
            illegal_q <= 1'b1;
            state_q   <= ST_HEAD;
          end else begin
            state_q <= ST_PUT;
          end
        end
        ST_PUT: if (wr_fire) begin
          done_q  <= 1'b1;
          state_q <= ST_HEAD;
        end
        default: state_q <= ST_HEAD;
      endcase
    end
  end

endmodule

// File: rtl/setcc_unit_chk.sv
module setcc_unit_chk #(
  parameter int RSEL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              reg_wr_valid,
  input logic              reg_wr_ready,
  input logic [RSEL_W-1:0] reg_wr_sel,
  input logic [15:0]       reg_wr_data,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [15:0]       mem_wr_data,
  input logic              done_o,
  input logic              illegal_o
);

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid && !reg_wr_ready |=> reg_wr_valid && $stable(reg_wr_data) && $stable(reg_wr_sel)); // R12
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_data)); // R12
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid || mem_wr_valid) |-> !in_ready); // R12
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid && reg_wr_ready) || (mem_wr_valid && mem_wr_ready) |=> done_o); // R13
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past((reg_wr_valid && reg_wr_ready) || (mem_wr_valid && mem_wr_ready))); // R13
  AST_DONE_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && illegal_o)); // R13
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_valid && mem_wr_valid)); // R9
  AST_BIT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |-> reg_wr_data[15:1] == 15'd0); // R9
  AST_ILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !reg_wr_valid && !mem_wr_valid); // R4

endmodule

bind setcc_unit setcc_unit_chk #(.RSEL_W(RSEL_W)) i_setcc_unit_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
  .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_data(mem_wr_data), .done_o(done_o), .illegal_o(illegal_o)
);

// File: tb/test_setcc_unit.sv
`timescale 1ns/1ps
module test_setcc_unit;

  localparam int CLK_PERIOD = 10;
  localparam int OPC = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_word = '0;
  logic flag_c = 0, flag_z = 0, flag_s = 0, flag_o = 0;
  logic [2:0] rf_rd_sel;
  logic [15:0] rf_rd_data;
  logic reg_wr_valid, mem_wr_valid;
  logic reg_wr_ready = 1'b0, mem_wr_ready = 1'b0;
  logic [2:0] reg_wr_sel;
  logic [15:0] reg_wr_data, mem_wr_addr, mem_wr_data;
  logic done_o, illegal_o;

  int n_checks = 0;
  int n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file model: register n holds 0x1000 + n*0x0111
  assign rf_rd_data = 16'h1000 + 16'(rf_rd_sel) * 16'h0111;

  setcc_unit #(.OPCODE(OPC), .NREG(8)) i_setcc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
    .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] head(input int src, input int dst, input int opc);
    return {5'(src), 5'(dst), 6'(opc)};
  endfunction

  function automatic logic expect_cond(input int code, input logic [3:0] f);
    logic c, z, s, o;
    {c, z, s, o} = f;
    case (code)
      0: return !c && !z;
      1: return !c;
      2: return c || z;
      3: return c;
      4: return z;
      5: return !z;
      6: return (s == o) && !z;
      7: return s == o;
      8: return (s != o) || z;
      9: return s != o;
      10: return o;
      11: return !o;
      12: return s;
      default: return !s;
    endcase
  endfunction

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    in_word = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // wait for a register request, stall it, accept it, check done
  task automatic take_reg(input int sel, input int data, input int stall, input string req);
    int t = 0;
    @(negedge clk);
    while (!reg_wr_valid && t < 10) begin @(negedge clk); t++; end
    check(reg_wr_valid && !mem_wr_valid, req, reg_wr_valid, 1);
    check(reg_wr_sel == 3'(sel) && reg_wr_data == 16'(data), req, reg_wr_data, data);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(reg_wr_valid && !in_ready && reg_wr_data == 16'(data), "R12", reg_wr_valid, 1);
    end
    reg_wr_ready = 1'b1;
    @(posedge clk);
    #1 reg_wr_ready = 1'b0;
    @(negedge clk);
    check(done_o && !reg_wr_valid, "R13", done_o, 1);
    @(negedge clk);
    check(!done_o, "R13", done_o, 0);
  endtask

  task automatic take_mem(input int addr, input int data, input int stall, input string req);
    int t = 0;
    @(negedge clk);
    while (!mem_wr_valid && t < 10) begin @(negedge clk); t++; end
    check(mem_wr_valid && !reg_wr_valid, req, mem_wr_valid, 1);
    check(mem_wr_addr == 16'(addr), req, mem_wr_addr, addr);
    check(mem_wr_data == 16'(data), req, mem_wr_data, data);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(mem_wr_valid && !in_ready && mem_wr_addr == 16'(addr), "R12", mem_wr_valid, 1);
    end
    mem_wr_ready = 1'b1;
    @(posedge clk);
    #1 mem_wr_ready = 1'b0;
    @(negedge clk);
    check(done_o && !mem_wr_valid, "R13", done_o, 1);
  endtask

  task automatic expect_illegal(input string req);
    @(negedge clk);
    check(illegal_o && !reg_wr_valid && !mem_wr_valid && !done_o, req, illegal_o, 1);
    @(negedge clk);
    check(!illegal_o && !reg_wr_valid && !mem_wr_valid && in_ready, req, illegal_o, 0);
  endtask

  task automatic t_reset();
    check(in_ready && !reg_wr_valid && !mem_wr_valid && !done_o && !illegal_o,
          "R13 reset", {in_ready, reg_wr_valid, mem_wr_valid, done_o, illegal_o}, 5'b10000);
  endtask

  // every selector against every flag pattern, register destination
  task automatic t_all_conditions();
    for (int code = 0; code < 14; code++) begin
      for (int f = 0; f < 16; f++) begin
        string req;
        req = (code < 4) ? "R5" : (code < 6) ? "R6" : (code < 10) ? "R7" : "R8";
        {flag_c, flag_z, flag_s, flag_o} = 4'(f);
        push(head(31, code % 8, OPC));
        push(16'(code));
        take_reg(code % 8, int'(expect_cond(code, 4'(f))), 0, req);
      end
    end
  endtask

  task automatic t_mem_abs();
    {flag_c, flag_z, flag_s, flag_o} = 4'b0100;
    push(head(31, 30, OPC));
    push(16'd4);
    push(16'hBEEF);
    take_mem(16'hBEEF, 1, 2, "R10");
  endtask

  task automatic t_mem_indirect();
    {flag_c, flag_z, flag_s, flag_o} = 4'b1000;
    push(head(31, 8 + 3, OPC));
    push(16'd3);
    take_mem(16'h1000 + 3 * 16'h0111, 1, 0, "R11");
    push(head(31, 16 + 5, OPC));
    push(16'd1);
    push(16'hFFF0);
    take_mem(16'(32'h1000 + 5 * 32'h0111 + 32'hFFF0), 0, 1, "R11");
  endtask

  task automatic t_backpressure();
    {flag_c, flag_z, flag_s, flag_o} = 4'b0010;
    push(head(31, 6, OPC));
    push(16'd12);
    take_reg(6, 1, 3, "R12");
  endtask

  task automatic t_bad_opcode();
    push(head(31, 2, 63));
    expect_illegal("R1");
    push(head(31, 2, OPC));
    push(16'd1);
    flag_c = 1'b0;
    take_reg(2, 1, 0, "R1");
  endtask

  task automatic t_bad_src();
    push(head(1, 2, OPC));
    expect_illegal("R2");
  endtask

  task automatic t_bad_dst();
    push(head(31, 31, OPC));
    expect_illegal("R3");
    push(head(31, 26, OPC));
    expect_illegal("R3");
  endtask

  task automatic t_bad_sel();
    push(head(31, 30, OPC));
    push(16'd14);
    push(16'd50);
    expect_illegal("R4");
    push(head(31, 4, OPC));
    push(16'hFFFF);
    expect_illegal("R4");
    {flag_c, flag_z, flag_s, flag_o} = 4'b0100;
    push(head(31, 4, OPC));
    push(16'd4);
    take_reg(4, 1, 0, "R4");
  endtask

  task automatic t_flag_sample();
    {flag_c, flag_z, flag_s, flag_o} = 4'b0100;
    push(head(31, 1, OPC));
    push(16'd4);
    flag_z = 1'b0;
    take_reg(1, 1, 2, "R14");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_conditions();
    t_mem_abs();
    t_mem_indirect();
    t_backpressure();
    t_bad_opcode();
    t_bad_src();
    t_bad_dst();
    t_bad_sel();
    t_flag_sample();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule